// File: doc/BRIEF.md
# Dual-Register Programmable Logic Macrocell

This block is one output cell of a small programmable logic device. The AND plane sits outside it and hands in a vector of evaluated product terms. The cell ORs those terms into sum terms and feeds two state registers from them. Each register can work as a D-type or a T-type register. Each has its own reset term and its own choice of clock: either the shared pin clock or a product-term clock of its own. The first register drives the pad. A dedicated product term drives the pad's output enable. Separate feedback lines carry each register's state and the pad's input value back to the array.

All clocking is synchronous to one system clock `clk`. A register's selected clock source is sampled on every `clk` edge, and the register acts on the edge where it sees that source go from 0 to 1.

Static configuration bits set up the cell:
- The first register's input can take the OR of all product terms instead of only its own group.
- The second register can be bypassed so that its input goes straight to the array as combinational feedback.
- A reduced compatibility mode turns off T-type operation, pin clocking and the bypass.

A preload strobe forces both registers to given values. A lock input disables preload and hides the second register's state from the observation port.

Top module: `plm_macrocell`

## Requirements
- R1: With the default parameters, `pt_in[3:0]`, `pt_in[7:4]` and `pt_in[11:8]` form sum groups 0, 1 and 2. Register 1's input is the OR of group 0 when `cfg_merge`=0, and the OR of all 12 terms when `cfg_merge`=1. Register 2's input is always the OR of group 1.
- R2: In D mode (`cfg_tmode[i]`=0), a register takes its input on the `clk` edge where its sampled clock source is 1 after being 0 on the previous edge. The new value is visible on the feedback port after that edge.
- R3: In T mode (`cfg_tmode[i]`=1), a register inverts its state at a detected clock edge when its input is 1, and holds its state when its input is 0.
- R4: When `cfg_pinclk[i]`=1, register i is clocked by `pin_clk` and `ck_term[i]` has no effect on it. When `cfg_pinclk[i]`=0, the reverse holds.
- R5: `rst_term[i]`=1 at a `clk` edge clears register i to 0. This overrides both a preload and a clock edge at the same edge. `rst_n`=0 clears both registers.
- R6: While unlocked, `pre_load`=1 at a `clk` edge loads `pre_d[0]` into register 1 and `pre_d[1]` into register 2.
- R7: While `lock`=1, `obs_q2` reads 0 in the same cycle and `pre_load` has no effect. When `lock` is 0, `obs_q2` shows register 2's state.
- R8: With `cfg_bypass2`=1, `fb_q2` carries register 2's input combinationally. With `cfg_bypass2`=0, `fb_q2` carries register 2's state.
- R9: With `cfg_legacy`=1, both registers behave as D-type, both are clocked by their product-term clocks, and `fb_q2` carries register 2's state, whatever `cfg_tmode`, `cfg_pinclk` and `cfg_bypass2` say.
- R10: `pad_out` equals register 1's state, `pad_oe` follows `oe_term`, and `fb_pin` follows `pad_in`, all combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset that clears both registers |
| pt_in | input | 12 | Evaluated product terms, grouped by 4 |
| pin_clk | input | 1 | Dedicated pin clock, sampled on `clk` |
| ck_term | input | 2 | Product-term clock for each register |
| rst_term | input | 2 | Product-term reset for each register |
| oe_term | input | 1 | Output-enable product term |
| cfg_tmode | input | 2 | 1 selects T-type for each register |
| cfg_pinclk | input | 2 | 1 selects the pin clock for each register |
| cfg_merge | input | 1 | Merge all sum groups into register 1's input |
| cfg_bypass2 | input | 1 | Route register 2's input to its feedback |
| cfg_legacy | input | 1 | Reduced compatibility feature subset |
| lock | input | 1 | Security lock |
| pre_load | input | 1 | Preload strobe |
| pre_d | input | 2 | Preload values for register 1 (bit 0) and register 2 (bit 1) |
| pad_in | input | 1 | Value seen at the pad |
| pad_out | output | 1 | Pad data, equal to register 1's state |
| pad_oe | output | 1 | Pad tri-state enable |
| fb_q1 | output | 1 | Register 1 feedback to the array |
| fb_q2 | output | 1 | Register 2 feedback, or its bypassed input |
| fb_pin | output | 1 | Pad input feedback to the array |
| obs_q2 | output | 1 | Observation of register 2, gated by the lock |

## Verification
Register results are due one `clk` edge after the stimulus. The bench raises a clock source at a falling edge, the next rising edge detects it and updates the register, and the result is sampled at the following falling edge. Preload and reset terms follow the same one-edge timing. Combinational results (bypass feedback, lock gating of `obs_q2`, and the pad and output-enable paths) are checked 1 ns after the inputs change, with no clock edge in between. Each clock pulse is lowered again in a separate cycle, so every detected edge is a fresh 0-to-1 transition.

// File: rtl/plm_pkg.sv
package plm_pkg;
   localparam int unsigned NUM_REGS = 2;

   typedef enum logic {
      REG_D = 1'b0,
      REG_T = 1'b1
   } reg_mode_e;
endpackage

// File: rtl/plm_sum_array.sv
module plm_sum_array #(
   parameter int unsigned PT_PER_SUM = 4,
   parameter int unsigned NUM_SUMS   = 3,
   localparam int unsigned PT_W      = PT_PER_SUM * NUM_SUMS
) (
   input  logic [PT_W-1:0]     pt_in,
   output logic [NUM_SUMS-1:0] sums,
   output logic                wide_sum
);
   for (genvar g = 0; g < NUM_SUMS; g++) begin : g_grp
      assign sums[g] = |pt_in[g*PT_PER_SUM +: PT_PER_SUM];
   end

   assign wide_sum = |sums;
endmodule

// File: rtl/plm_flop.sv
module plm_flop
   import plm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clk_src,
   input  logic      clr,
   input  logic      load_en,
   input  logic      load_val,
   input  logic      din,
   input  reg_mode_e mode,
   output logic      q
);
   logic src_prev;
   logic edge_seen;

   assign edge_seen = clk_src & ~src_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_prev <= 1'b0;
         q        <= 1'b0;
      end else begin
         src_prev <= clk_src;
         if (clr)
            q <= 1'b0;
         else if (load_en)
            q <= load_val;
         else if (edge_seen)
            q <= (mode == REG_T) ? (q ^ din) : din;
      end
   end
endmodule

// File: rtl/plm_macrocell.sv
module plm_macrocell
   import plm_pkg::*;
#(
   parameter int unsigned PT_PER_SUM = 4,
   parameter int unsigned NUM_SUMS   = 3,
   localparam int unsigned PT_W      = PT_PER_SUM * NUM_SUMS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PT_W-1:0]     pt_in,
   input  logic                pin_clk,
   input  logic [NUM_REGS-1:0] ck_term,
   input  logic [NUM_REGS-1:0] rst_term,
   input  logic                oe_term,
   input  logic [NUM_REGS-1:0] cfg_tmode,
   input  logic [NUM_REGS-1:0] cfg_pinclk,
   input  logic                cfg_merge,
   input  logic                cfg_bypass2,
   input  logic                cfg_legacy,
   input  logic                lock,
   input  logic                pre_load,
   input  logic [NUM_REGS-1:0] pre_d,
   input  logic                pad_in,
   output logic                pad_out,
   output logic                pad_oe,
   output logic                fb_q1,
   output logic                fb_q2,
   output logic                fb_pin,
   output logic                obs_q2
);
   if (PT_PER_SUM < 1) begin : g_bad_pt
      $error("PT_PER_SUM must be at least 1");
   end
   if (NUM_SUMS < 2) begin : g_bad_sums
      $error("NUM_SUMS must be at least 2");
   end

   logic [NUM_SUMS-1:0] sums;
   logic                wide_sum;
   logic [NUM_REGS-1:0] reg_d;
   logic [NUM_REGS-1:0] reg_q;
   logic                load_ok;

   plm_sum_array #(
      .PT_PER_SUM (PT_PER_SUM),
      .NUM_SUMS   (NUM_SUMS)
   ) u_sums (
      .pt_in    (pt_in),
      .sums     (sums),
      .wide_sum (wide_sum)
   );

   assign reg_d[0] = cfg_merge ? wide_sum : sums[0];
   assign reg_d[1] = sums[1];
   assign load_ok  = pre_load & ~lock;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic      src;
      reg_mode_e mode;

      assign src  = (cfg_pinclk[r] & ~cfg_legacy) ? pin_clk : ck_term[r];
      assign mode = reg_mode_e'(cfg_tmode[r] & ~cfg_legacy);

      plm_flop u_flop (
         .clk      (clk),
         .rst_n    (rst_n),
         .clk_src  (src),
         .clr      (rst_term[r]),
         .load_en  (load_ok),
         .load_val (pre_d[r]),
         .din      (reg_d[r]),
         .mode     (mode),
         .q        (reg_q[r])
      );
   end

   assign pad_out = reg_q[0];
   assign pad_oe  = oe_term;
   assign fb_q1   = reg_q[0];
   assign fb_q2   = (cfg_bypass2 & ~cfg_legacy) ? reg_d[1] : reg_q[1];
   assign fb_pin  = pad_in;
   assign obs_q2  = lock ? 1'b0 : reg_q[1];
endmodule

// File: rtl/plm_macrocell_chk.sv
module plm_macrocell_chk
   import plm_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_REGS-1:0] ck_term,
   input logic [NUM_REGS-1:0] rst_term,
   input logic [NUM_REGS-1:0] cfg_pinclk,
   input logic                cfg_legacy,
   input logic                lock,
   input logic                pre_load,
   input logic                fb_q1,
   input logic                fb_q2,
   input logic                obs_q2
);
   // R5
   q1_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_term[0] |=> (fb_q1 == 1'b0));

   // R7
   obs_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock |-> (obs_q2 == 1'b0));

   // R7
   locked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && pre_load && !rst_term[0] && !ck_term[0]
       && (!cfg_pinclk[0] || cfg_legacy)) |=> $stable(fb_q1));

   // R9
   legacy_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_legacy && !lock) |-> (fb_q2 == obs_q2));
endmodule

bind plm_macrocell plm_macrocell_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ck_term    (ck_term),
   .rst_term   (rst_term),
   .cfg_pinclk (cfg_pinclk),
   .cfg_legacy (cfg_legacy),
   .lock       (lock),
   .pre_load   (pre_load),
   .fb_q1      (fb_q1),
   .fb_q2      (fb_q2),
   .obs_q2     (obs_q2)
);

// File: tb/plm_macrocell_bench.sv
`timescale 1ns/1ps
module plm_macrocell_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] pt_in = '0;
   logic        pin_clk = 1'b0;
   logic [1:0]  ck_term = '0, rst_term = '0, cfg_tmode = '0, cfg_pinclk = '0, pre_d = '0;
   logic        oe_term = 1'b0, cfg_merge = 1'b0, cfg_bypass2 = 1'b0, cfg_legacy = 1'b0;
   logic        lock = 1'b0, pre_load = 1'b0, pad_in = 1'b0;
   logic        pad_out, pad_oe, fb_q1, fb_q2, fb_pin, obs_q2;
   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   plm_macrocell u_plm_macrocell (
      .clk(clk), .rst_n(rst_n), .pt_in(pt_in), .pin_clk(pin_clk),
      .ck_term(ck_term), .rst_term(rst_term), .oe_term(oe_term),
      .cfg_tmode(cfg_tmode), .cfg_pinclk(cfg_pinclk), .cfg_merge(cfg_merge),
      .cfg_bypass2(cfg_bypass2), .cfg_legacy(cfg_legacy), .lock(lock),
      .pre_load(pre_load), .pre_d(pre_d), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .fb_q1(fb_q1), .fb_q2(fb_q2),
      .fb_pin(fb_pin), .obs_q2(obs_q2)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic nstep();
      @(negedge clk);
   endtask

   // raise a clock source for one edge, lower it over the next
   task automatic pulse_ck(input int r);
      ck_term[r] = 1'b1; nstep();
      ck_term[r] = 1'b0; nstep();
   endtask

   task automatic pulse_pin();
      pin_clk = 1'b1; nstep();
      pin_clk = 1'b0; nstep();
   endtask

   task automatic preload(input logic [1:0] v);
      pre_d = v; pre_load = 1'b1; nstep();
      pre_load = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic exp_q;
      logic [5:0] tseq;
      repeat (3) nstep();
      // R5 reset state
      chk("R5 reset q1", fb_q1, 1'b0);
      chk("R5 reset q2", obs_q2, 1'b0);
      rst_n = 1'b1; nstep();

      // R1 R2: full sweep of product terms, with and without merge
      for (int m = 0; m < 2; m++) begin
         cfg_merge = m[0];
         for (int p = 0; p < 4096; p++) begin
            pt_in = p[11:0];
            pulse_ck(0);
            exp_q = m[0] ? (p != 0) : ((p & 15) != 0);
            chk("R1 R2 q1 sum", fb_q1, exp_q);
            chk("R10 pad_out", pad_out, exp_q);
         end
      end
      cfg_merge = 1'b0;
      for (int p = 0; p < 16; p++) begin
         pt_in = {4'hF, p[3:0], 4'hF};
         pulse_ck(1);
         chk("R1 R2 q2 sum", fb_q2, p != 0);
         chk("R7 obs unlocked", obs_q2, p != 0);
      end

      // R3 T mode
      cfg_tmode[0] = 1'b1;
      preload(2'b00);
      chk("R6 preload zero", fb_q1, 1'b0);
      tseq = 6'b101101;
      exp_q = 1'b0;
      for (int k = 0; k < 6; k++) begin
         pt_in = {8'h00, 3'b000, tseq[k]};
         pulse_ck(0);
         exp_q = exp_q ^ tseq[k];
         chk("R3 toggle", fb_q1, exp_q);
      end
      cfg_tmode[0] = 1'b0;

      // R4 clock source
      preload(2'b00);
      cfg_pinclk[0] = 1'b1; pt_in = 12'h001;
      pulse_ck(0);
      chk("R4 pt clock ignored", fb_q1, 1'b0);
      pulse_pin();
      chk("R4 pin clock", fb_q1, 1'b1);
      cfg_pinclk[0] = 1'b0; pt_in = 12'h000;
      pulse_pin();
      chk("R4 pin clock ignored", fb_q1, 1'b1);

      // R5 reset term beats preload and clock edge
      pt_in = 12'h0F1;
      rst_term = 2'b11; pre_load = 1'b1; pre_d = 2'b11; ck_term = 2'b11; nstep();
      chk("R5 clear q1", fb_q1, 1'b0);
      chk("R5 clear q2", fb_q2, 1'b0);
      rst_term = 2'b00; pre_load = 1'b0; ck_term = 2'b00; nstep();

      // R6 preload
      preload(2'b10);
      chk("R6 load q1", fb_q1, 1'b0);
      chk("R6 load q2", obs_q2, 1'b1);

      // R7 lock
      lock = 1'b1; #1;
      chk("R7 obs hidden", obs_q2, 1'b0);
      preload(2'b01);
      chk("R7 load blocked q1", fb_q1, 1'b0);
      chk("R7 load blocked q2", fb_q2, 1'b1);
      lock = 1'b0; #1;
      chk("R7 obs restored", obs_q2, 1'b1);

      // R8 bypass
      cfg_bypass2 = 1'b1;
      for (int p = 0; p < 16; p++) begin
         pt_in = {4'h0, p[3:0], 4'h0}; #1;
         chk("R8 bypass fb", fb_q2, p != 0);
      end
      chk("R8 q2 held", obs_q2, 1'b1);
      cfg_bypass2 = 1'b0; #1;
      chk("R8 bypass off", fb_q2, 1'b1);

      // R9 legacy
      nstep();
      cfg_legacy = 1'b1; cfg_tmode = 2'b11; cfg_pinclk = 2'b11; cfg_bypass2 = 1'b1;
      pt_in = 12'h000; #1;
      chk("R9 no bypass", fb_q2, 1'b1);
      pt_in = 12'h001;
      pulse_pin();
      chk("R9 pin clock off", fb_q1, 1'b0);
      pulse_ck(0);
      chk("R9 D type 1", fb_q1, 1'b1);
      pulse_ck(0);
      chk("R9 D type 2", fb_q1, 1'b1);
      cfg_legacy = 1'b0; cfg_tmode = 2'b00; cfg_pinclk = 2'b00; cfg_bypass2 = 1'b0;

      // R10 pad paths
      for (int v = 0; v < 4; v++) begin
         oe_term = v[0]; pad_in = v[1]; #1;
         chk("R10 pad_oe", pad_oe, v[0]);
         chk("R10 fb_pin", fb_pin, v[1]);
      end

      nstep();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule